// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a small window onto a larger bank of internal 16-bit registers. The host sees six words: a status word, an address word and four data words. Loading the address word starts an internal transaction. The top bit of the address value chooses between a read and a write. The remaining bits, including the half-select LSB, go out on a request/acknowledge interface to the register bank. While the transaction runs, a busy flag in the status word stays set, and the host polls it until it clears.

A write sends all four data words to the bank at once. The host loads them before the address write, with data word 0 holding the low 16 bits and data word 1 the high 16 bits of a 32-bit value. A read places the returned 16-bit value in data word 0, so a 32-bit register is read in two passes: once at its even base address and once with address bit 0 set.

The status word also holds two active-low reset controls, one global and one for the codec side. Both are driven out of the block as pins. Software asserts the resets by writing zero to them and releases them by writing ones.

Top module: `iap_port`

## Requirements
- R1: A host write of value V to the address word (hostSel = 1) while idle starts a transaction. From the next cycle bankReq is 1, bankAddr equals V[6:0] and bankWrite equals the inverse of V[7].
- R2: The address value's bit 7 set to 1 requests a read and set to 0 requests a write. A write presents bankWrData = {data3, data2, data1, data0}, with data word 0 in bits 15:0 and data word 1 in bits 31:16.
- R3: Status bit 0 (busy) and bankReq rise in the cycle after the launching address write. They stay high until the clock edge that samples bankAck high, and are low from the cycle after that edge.
- R4: When a read completes, data word 0 takes the value of bankRdData sampled with bankAck. Data words 1 to 3 are unchanged.
- R5: Bit 0 of the address selects the half of a 32-bit register and passes to bankAddr[0] unchanged. A read at base address B returns the low half and a read at B|1 returns the high half.
- R6: Status bit 1 drives globalRstN and status bit 2 drives codecRstN, both active low. Writing 0 to a bit asserts its reset and writing 1 releases it. Host writes to status bit 0 have no effect.
- R7: A host write to the address word while busy is ignored. No new request is made and the address word keeps the value of the running transaction.
- R8: Host writes to the data words while busy are ignored, so the write payload stays stable during a transaction.
- R9: hostRdData returns, combinationally from hostSel: 0 the status word, 1 the last accepted address value (zero-extended), 2 to 5 data words 0 to 3, and 0 for other selects.
- R10: After reset, busy is 0, bankReq is 0, both reset outputs are 0 (asserted), and the address and data words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for the selected word |
| hostSel | input | 3 | Host word select: 0 status, 1 address, 2..5 data 0..3 |
| hostWrData | input | 16 | Host write value |
| hostRdData | output | 16 | Readback of the selected word |
| bankReq | output | 1 | Internal transaction request, held until acknowledged |
| bankWrite | output | 1 | 1 for a write transaction, 0 for a read |
| bankAddr | output | 7 | Internal register address; bit 0 selects the 16-bit half |
| bankWrData | output | 64 | Write payload, data word 0 in the lowest bits |
| bankAck | input | 1 | Bank acknowledge, one cycle |
| bankRdData | input | 16 | Bank read value, valid with bankAck |
| globalRstN | output | 1 | Global reset control, active low |
| codecRstN | output | 1 | Codec reset control, active low |

## Verification
The assertions check on every cycle that busy holds until the acknowledge and drops right after it. They also check that no launch happens while busy, and that the address and write payload stay frozen for the whole transaction. Only the bench scenarios can show the rest. Those cover the read/write encoding reaching the bank, the field order of the payload, and the two-pass 32-bit read through the half-select bit. They also cover the reset-control bits and the exact number of cycles that busy stays visible to a polling host.

// File: rtl/iap_pkg.sv
package iap_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} iapState_e;

  typedef struct packed {
    logic busy;
    logic launch;
    logic finish;
    logic capture;
  } iapStrobes_t;

  localparam int unsigned SEL_STATUS  = 0;
  localparam int unsigned SEL_ADDR    = 1;
  localparam int unsigned SEL_DATA0   = 2;
  localparam int unsigned ST_BUSY_BIT = 0;
  localparam int unsigned ST_GRST_BIT = 1;
  localparam int unsigned ST_CRST_BIT = 2;
endpackage

// File: rtl/iap_ctrl.sv
module iap_ctrl
  import iap_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [SEL_W-1:0] hostSel,
  input  logic             bankAck,
  input  logic             isWrite,
  output iapStrobes_t      strobes
);
  iapState_e state;
  logic addrWr;

  assign addrWr = hostWrEn && (hostSel == SEL_W'(SEL_ADDR));

  always_comb begin
    strobes.busy    = (state == ST_WAIT);
    strobes.launch  = (state == ST_IDLE) && addrWr;
    strobes.finish  = (state == ST_WAIT) && bankAck;
    strobes.capture = strobes.finish && !isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (addrWr) state <= ST_WAIT;
        ST_WAIT: if (bankAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !bankAck) |=> strobes.busy); // R3
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && bankAck) |=> !strobes.busy); // R3
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |-> !strobes.launch); // R7
endmodule

// File: rtl/iap_datapath.sv
module iap_datapath
  import iap_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic [SEL_W-1:0]           hostSel,
  input  logic [DATA_W-1:0]          hostWrData,
  output logic [DATA_W-1:0]          hostRdData,
  input  iapStrobes_t                strobes,
  input  logic [DATA_W-1:0]          bankRdData,
  output logic                       bankWrite,
  output logic [ADDR_W-2:0]          bankAddr,
  output logic [NUM_DATA*DATA_W-1:0] bankWrData,
  output logic                       globalRstN,
  output logic                       codecRstN
);
  localparam int unsigned RD_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataRegs [NUM_DATA];
  logic [1:0]        rstBits;
  logic [DATA_W-1:0] statusWord;
  logic              statusWr;

  assign statusWr = hostWrEn && (hostSel == SEL_W'(SEL_STATUS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobes.launch) begin
      addrReg <= hostWrData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstBits <= '0;
    end else if (statusWr) begin
      rstBits <= hostWrData[ST_CRST_BIT:ST_GRST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DATA; i++) dataRegs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (i == 0 && strobes.capture) begin
          dataRegs[i] <= bankRdData;
        end else if (hostWrEn && !strobes.busy &&
                     hostSel == SEL_W'(SEL_DATA0 + i)) begin
          dataRegs[i] <= hostWrData;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_DATA; g++) begin : gPayload
    assign bankWrData[g*DATA_W +: DATA_W] = dataRegs[g];
  end

  assign bankWrite  = !addrReg[RD_BIT];
  assign bankAddr   = addrReg[ADDR_W-2:0];
  assign globalRstN = rstBits[0];
  assign codecRstN  = rstBits[1];

  always_comb begin
    statusWord = '0;
    statusWord[ST_BUSY_BIT] = strobes.busy;
    statusWord[ST_GRST_BIT] = rstBits[0];
    statusWord[ST_CRST_BIT] = rstBits[1];
  end

  always_comb begin
    hostRdData = '0;
    if (hostSel == SEL_W'(SEL_STATUS)) hostRdData = statusWord;
    if (hostSel == SEL_W'(SEL_ADDR))   hostRdData = DATA_W'(addrReg);
    for (int i = 0; i < NUM_DATA; i++) begin
      if (hostSel == SEL_W'(SEL_DATA0 + i)) hostRdData = dataRegs[i];
    end
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busy |=> $stable(addrReg)); // R7
  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !strobes.finish) |=> $stable(bankWrData)); // R8
endmodule

// File: rtl/iap_port.sv
module iap_port
  import iap_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned SEL_W   = $clog2(NUM_DATA + 2)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic [SEL_W-1:0]           hostSel,
  input  logic [DATA_W-1:0]          hostWrData,
  output logic [DATA_W-1:0]          hostRdData,
  output logic                       bankReq,
  output logic                       bankWrite,
  output logic [ADDR_W-2:0]          bankAddr,
  output logic [NUM_DATA*DATA_W-1:0] bankWrData,
  input  logic                       bankAck,
  input  logic [DATA_W-1:0]          bankRdData,
  output logic                       globalRstN,
  output logic                       codecRstN
);
  iapStrobes_t strobes;

  iap_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .bankAck(bankAck), .isWrite(bankWrite), .strobes(strobes)
  );

  iap_datapath #(
    .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .strobes(strobes),
    .bankRdData(bankRdData), .bankWrite(bankWrite), .bankAddr(bankAddr),
    .bankWrData(bankWrData), .globalRstN(globalRstN), .codecRstN(codecRstN)
  );

  assign bankReq = strobes.busy;

  AST_REQ_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (bankReq && !bankAck) |=> (bankReq && $stable(bankAddr) && $stable(bankWrite))); // R1
endmodule

// File: tb/iap_port_tb.sv
module iap_port_tb;
  localparam int LAT = 3;
  localparam logic [2:0] S_STAT = 3'd0, S_ADDR = 3'd1, S_D0 = 3'd2, S_D1 = 3'd3,
                         S_D2 = 3'd4, S_D3 = 3'd5;
  // {address (even), low half, high half}
  localparam logic [38:0] VEC [4] = '{
    {7'h04, 16'h1234, 16'hABCD},
    {7'h10, 16'h0000, 16'hFFFF},
    {7'h3E, 16'h8001, 16'h7FFE},
    {7'h7E, 16'hFFFF, 16'h0001}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [2:0] hostSel = 3'd0;
  logic [15:0] hostWrData = 16'd0;
  logic [15:0] hostRdData;
  logic bankReq, bankWrite, bankAck, globalRstN, codecRstN;
  logic [6:0] bankAddr;
  logic [63:0] bankWrData;
  logic [15:0] bankRdData;

  logic [15:0] mem [128];
  int cnt;
  int reqCount;
  logic reqPrev;
  logic [6:0] lastWrAddr;
  logic [63:0] lastWrData;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  iap_port u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .bankReq(bankReq),
    .bankWrite(bankWrite), .bankAddr(bankAddr), .bankWrData(bankWrData),
    .bankAck(bankAck), .bankRdData(bankRdData), .globalRstN(globalRstN),
    .codecRstN(codecRstN)
  );

  assign bankRdData = mem[bankAddr];

  // bank model: acknowledges LAT cycles after a request appears
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankAck <= 1'b0; cnt <= 0; reqCount <= 0; reqPrev <= 1'b0;
      lastWrAddr <= '0; lastWrData <= '0;
      for (int i = 0; i < 128; i++) mem[i] <= 16'(i * 16'h0101);
    end else begin
      reqPrev <= bankReq;
      if (bankReq && !reqPrev) reqCount <= reqCount + 1;
      bankAck <= 1'b0;
      if (bankReq && !bankAck) begin
        if (cnt == LAT - 1) begin
          bankAck <= 1'b1;
          cnt <= 0;
          if (bankWrite) begin
            lastWrAddr <= bankAddr;
            lastWrData <= bankWrData;
            mem[bankAddr] <= bankWrData[15:0];
            if (!bankAddr[0]) mem[bankAddr | 7'd1] <= bankWrData[31:16];
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic hostWr(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = sel; hostWrData = val;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [2:0] sel, output logic [15:0] val);
    @(negedge clk);
    hostSel = sel;
    #1 val = hostRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int k = 0; k < 50; k++) begin
      hostRd(S_STAT, s);
      if (!s[0]) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int busyCycles;
    int rc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    hostRd(S_STAT, v); check("R10 status", v, 16'h0000);
    check("R10 bankReq", bankReq, 1'b0);
    check("R10 resets", {globalRstN, codecRstN}, 2'b00);
    hostRd(S_ADDR, v); check("R10 address", v, 16'h0000);
    hostRd(S_D3, v);   check("R10 data3", v, 16'h0000);

    // vector table: 32-bit write, then two-half read
    for (int n = 0; n < 4; n++) begin
      logic [6:0] a; logic [15:0] lo, hi;
      {a, lo, hi} = VEC[n];
      hostWr(S_D0, lo); hostWr(S_D1, hi); hostWr(S_D2, 16'h0); hostWr(S_D3, 16'h0);
      hostWr(S_ADDR, {8'h00, 1'b0, a});
      waitIdle();
      check("R2 write addr", lastWrAddr, a);
      check("R2 write payload", lastWrData, {32'h0, hi, lo});
      hostWr(S_D0, 16'h5A5A);
      hostWr(S_ADDR, {8'h00, 1'b1, a});
      waitIdle();
      hostRd(S_D0, v); check("R5 low half", v, lo);
      hostRd(S_D1, v); check("R4 data1 kept", v, hi);
      hostWr(S_ADDR, {8'h00, 1'b1, a | 7'd1});
      waitIdle();
      hostRd(S_D0, v); check("R5 high half", v, hi);
    end

    // R1 launch outputs and R2 payload field order
    hostWr(S_D0, 16'h1111); hostWr(S_D1, 16'h2222);
    hostWr(S_D2, 16'h3333); hostWr(S_D3, 16'h4444);
    @(negedge clk);
    hostWrEn = 1'b1; hostSel = S_ADDR; hostWrData = 16'h0025;
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R1 req", bankReq, 1'b1);
    check("R1 addr", bankAddr, 7'h25);
    check("R1 write", bankWrite, 1'b1);
    waitIdle();
    check("R2 field order", lastWrData, 64'h4444_3333_2222_1111);

    // R3 busy duration seen by polling
    hostWr(S_ADDR, 16'h0090);
    busyCycles = 1;
    for (int k = 0; k < 20; k++) begin
      hostRd(S_STAT, v);
      if (v[0]) busyCycles++; else break;
    end
    check("R3 busy cycles", busyCycles, LAT + 1);
    check("R3 req low after ack", bankReq, 1'b0);

    // R7/R8 writes while busy are ignored
    hostWr(S_D2, 16'h1234);
    rc = reqCount;
    hostWr(S_ADDR, 16'h0090);   // read of 0x10
    hostWr(S_ADDR, 16'h0022);   // busy: ignored
    hostWr(S_D2, 16'hBEEF);     // busy: ignored
    waitIdle();
    check("R7 one request", reqCount - rc, 1);
    hostRd(S_ADDR, v); check("R7 address kept", v, 16'h0090);
    hostRd(S_D2, v);   check("R8 data2 kept", v, 16'h1234);
    hostRd(S_D0, v);   check("R4 read result", v, 16'h0000);

    // R6 reset-control bits
    hostWr(S_STAT, 16'h0006);
    check("R6 both released", {globalRstN, codecRstN}, 2'b11);
    hostWr(S_STAT, 16'h0002);
    check("R6 global only", {globalRstN, codecRstN}, 2'b10);
    hostWr(S_STAT, 16'h0004);
    check("R6 codec only", {globalRstN, codecRstN}, 2'b01);
    rc = reqCount;
    hostWr(S_STAT, 16'h0001);
    hostRd(S_STAT, v); check("R6 busy bit not writable", v, 16'h0000);
    check("R6 no request", reqCount - rc, 0);
    check("R6 both asserted", {globalRstN, codecRstN}, 2'b00);

    // R9 read map, unused selects
    hostRd(3'd6, v); check("R9 unused select", v, 16'h0000);
    hostRd(S_D3, v); check("R9 data3", v, 16'h4444);

    summary();
    $finish;
  end
endmodule